// File: doc/BRIEF.md
# Slave-Mode Timer Counter

An up/down counter with a wrap limit. A 3-bit slave-mode code decides where its count steps come from: every clock cycle, edges of a two-channel quadrature decoder, or rising edges of one selected trigger line. The same code also lets the selected trigger restart the count, gate it, or start it running.

The count wraps at a programmable limit and raises a single-cycle update pulse when it wraps. The limit can be written either directly or through a preload shadow that takes effect only at the next update. Rising edges on triggers and encoder channels are found by comparing each input with a registered copy of its previous value.

Top module: `slv_timer`

## Requirements
- R1: While rst_ni is low and right after it is released, count_o is 0, update_o is 0, the run flag is clear and the active limit equals parameter RST_PRESET.
- R2: Mode code 0 steps the count once per clock cycle while counting is allowed. dir_down_i=0 adds 1 and dir_down_i=1 subtracts 1. Mode codes 4 and 6 also step once per cycle.
- R3: Counting is allowed when enable_i is 1 or the run flag is set. When neither is true, count_o holds its value in every mode.
- R4: Counting up, a step taken when the count equals the active limit loads 0. Counting down, a step taken when the count is 0 loads the active limit. update_o is 1 for exactly the cycle in which that wrapped value first appears on count_o, and is 0 otherwise.
- R5: A pulse on preset_wr_i stores preset_i in the shadow. With preload_en_i=0 the active limit takes the new value on the same edge. With preload_en_i=1 the active limit takes the shadow value on the edge that produces the next wrap.
- R6: Mode codes 1, 2 and 3 step on encoder edges. Code 1 uses edges of enc_b_i only, code 2 uses edges of enc_a_i only, and code 3 uses edges of both, with no step if both channels change in the same cycle. An edge of A counts down when the new A equals B, otherwise up. An edge of B counts down when the new B differs from A, otherwise up. In these modes dir_down_i is ignored.
- R7: In mode code 4 the count steps every cycle. A rising edge on the selected trigger instead loads the starting value for the current direction (0 up, the active limit down), and this reload raises no update pulse.
- R8: In mode code 5 the count steps only in cycles where the selected trigger is 1. When the trigger is 0 the count holds and is not cleared.
- R9: In mode code 6 a rising edge on the selected trigger sets the run flag, which allows counting without enable_i. The count is not cleared. run_clr_i clears the flag, and the clear wins over a coincident set.
- R10: In mode code 7 the count takes one step for each rising edge of the selected trigger, and none otherwise.
- R11: The selected trigger is bit trig_sel_i of trig_i, so index 0 is trig_i[0]. A rising edge is seen on the first clock edge at which the selected line is 1 after being sampled 0 on the edge before. Edges on unselected lines have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 3 | Slave-mode code 0..7 |
| trig_sel_i | input | $clog2(N_TRIG) | Index of the trigger line in use |
| dir_down_i | input | 1 | 1 = count down (modes not using the encoder) |
| enable_i | input | 1 | Counting enable |
| run_clr_i | input | 1 | Clears the run flag set by trigger-start |
| preset_i | input | CNT_W | Limit value to write |
| preset_wr_i | input | 1 | Write strobe for preset_i |
| preload_en_i | input | 1 | 1 = apply the written limit at the next update |
| trig_i | input | N_TRIG | Trigger lines |
| enc_a_i | input | 1 | Encoder channel A |
| enc_b_i | input | 1 | Encoder channel B |
| count_o | output | CNT_W | Counter value |
| update_o | output | 1 | Single-cycle wrap pulse |

## Verification
The bench targets the wrap boundaries in both directions. A design that compared against the wrong value or missed the pulse would show an off-by-one count or a missing or late update_o. The bench writes a limit with preload on while the old limit is still counting out, so a limit applied too early moves the wrap point. The encoder is driven forward and then backward in each of its three modes, which catches a swapped channel or an inverted direction rule. The trigger modes use pulses on unselected lines and the reset-mode reload, which would show up as extra steps or a spurious update pulse.

// File: rtl/slv_timer_pkg.sv
package slv_timer_pkg;
  typedef enum logic [2:0] {
    SM_INT    = 3'd0,
    SM_ENC_B  = 3'd1,
    SM_ENC_A  = 3'd2,
    SM_ENC_AB = 3'd3,
    SM_RST    = 3'd4,
    SM_GATE   = 3'd5,
    SM_START  = 3'd6,
    SM_EXT    = 3'd7
  } slv_mode_e;
endpackage

// File: rtl/slv_trig_front.sv
module slv_trig_front #(
  parameter int N_TRIG = 4,
  localparam int SEL_W = (N_TRIG > 1) ? $clog2(N_TRIG) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_TRIG-1:0] trig_i,
  input  logic [SEL_W-1:0]  sel_i,
  output logic              lvl_o,
  output logic              rise_o
);
  logic [N_TRIG-1:0] hit;
  logic              lvl_q;

  for (genvar g = 0; g < N_TRIG; g++) begin : g_sel
    assign hit[g] = trig_i[g] & (sel_i == SEL_W'(g));
  end

  assign lvl_o  = |hit;
  assign rise_o = lvl_o & ~lvl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lvl_q <= 1'b0;
    else         lvl_q <= lvl_o;
  end

  AST_RISE_NEEDS_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> lvl_q) else $error("rise without high sample"); // R11
endmodule

// File: rtl/slv_quad_dec.sv
module slv_quad_dec (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic a_i,
  input  logic b_i,
  input  logic use_a_i,
  input  logic use_b_i,
  output logic step_o,
  output logic down_o
);
  logic a_q, b_q, ka, kb;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_q <= 1'b0;
      b_q <= 1'b0;
    end else begin
      a_q <= a_i;
      b_q <= b_i;
    end
  end

  // simultaneous edges on both used channels are dropped
  assign ka = use_a_i & (a_i ^ a_q) & ~(use_b_i & (b_i ^ b_q));
  assign kb = use_b_i & (b_i ^ b_q) & ~(use_a_i & (a_i ^ a_q));

  assign step_o = ka | kb;
  assign down_o = ka ? (a_i == b_i) : (b_i != a_i);

  AST_ENC_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!use_a_i && !use_b_i) |-> !step_o) else $error("encoder step while unused"); // R6
endmodule

// File: rtl/slv_cnt_core.sv
module slv_cnt_core #(
  parameter int CNT_W = 16,
  parameter logic [CNT_W-1:0] RST_PRESET = '1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             tick_i,
  input  logic             down_i,
  input  logic             reload_i,
  input  logic [CNT_W-1:0] preset_i,
  input  logic             preset_wr_i,
  input  logic             preload_en_i,
  output logic [CNT_W-1:0] count_o,
  output logic             update_o
);
  logic [CNT_W-1:0] cnt_q, act_q, shd_q, start_v;
  logic             upd_q, wrap;

  assign start_v = down_i ? act_q : '0;
  assign wrap    = en_i & tick_i & ~reload_i & (down_i ? (cnt_q == '0) : (cnt_q == act_q));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      upd_q <= 1'b0;
    end else begin
      upd_q <= wrap;
      if (en_i && reload_i)     cnt_q <= start_v;
      else if (wrap)            cnt_q <= start_v;
      else if (en_i && tick_i)  cnt_q <= down_i ? cnt_q - 1'b1 : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shd_q <= RST_PRESET;
      act_q <= RST_PRESET;
    end else begin
      if (preset_wr_i) shd_q <= preset_i;
      if (preset_wr_i && !preload_en_i) act_q <= preset_i;
      else if (wrap)                    act_q <= shd_q;
    end
  end

  assign count_o  = cnt_q;
  assign update_o = upd_q;

  AST_HOLD_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> ($stable(cnt_q) && !upd_q)) else $error("count moved while off"); // R3
  AST_STEP_UP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && tick_i && !reload_i && !down_i && cnt_q != act_q) |=>
    (cnt_q == CNT_W'($past(cnt_q) + 1'b1) && !upd_q)) else $error("bad up step"); // R2
  AST_UP_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && tick_i && !reload_i && !down_i && cnt_q == act_q) |=>
    (cnt_q == '0 && upd_q)) else $error("bad up wrap"); // R4
  AST_DN_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && tick_i && !reload_i && down_i && cnt_q == '0) |=>
    (cnt_q == $past(act_q) && upd_q)) else $error("bad down wrap"); // R4
  AST_RELOAD_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && reload_i) |=> !upd_q) else $error("reload raised update"); // R7
endmodule

// File: rtl/slv_timer.sv
module slv_timer
  import slv_timer_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int N_TRIG = 4,
  parameter logic [CNT_W-1:0] RST_PRESET = '1,
  localparam int SEL_W = (N_TRIG > 1) ? $clog2(N_TRIG) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [2:0]        mode_i,
  input  logic [SEL_W-1:0]  trig_sel_i,
  input  logic              dir_down_i,
  input  logic              enable_i,
  input  logic              run_clr_i,
  input  logic [CNT_W-1:0]  preset_i,
  input  logic              preset_wr_i,
  input  logic              preload_en_i,
  input  logic [N_TRIG-1:0] trig_i,
  input  logic              enc_a_i,
  input  logic              enc_b_i,
  output logic [CNT_W-1:0]  count_o,
  output logic              update_o
);
  slv_mode_e mode;
  logic      lvl, rise, enc_step, enc_dn, use_a, use_b;
  logic      run_q, en_eff, tick, dn, reload;

  assign mode  = slv_mode_e'(mode_i);
  assign use_a = (mode == SM_ENC_A) || (mode == SM_ENC_AB);
  assign use_b = (mode == SM_ENC_B) || (mode == SM_ENC_AB);

  slv_trig_front #(.N_TRIG(N_TRIG)) u_trig (
    .clk_i (clk_i), .rst_ni (rst_ni), .trig_i (trig_i), .sel_i (trig_sel_i),
    .lvl_o (lvl), .rise_o (rise)
  );

  slv_quad_dec u_quad (
    .clk_i (clk_i), .rst_ni (rst_ni), .a_i (enc_a_i), .b_i (enc_b_i),
    .use_a_i (use_a), .use_b_i (use_b), .step_o (enc_step), .down_o (enc_dn)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          run_q <= 1'b0;
    else if (run_clr_i)                   run_q <= 1'b0;
    else if (mode == SM_START && rise)    run_q <= 1'b1;
  end

  assign en_eff = enable_i | run_q;
  assign reload = (mode == SM_RST) & rise;

  always_comb begin
    tick = 1'b0;
    dn   = dir_down_i;
    unique case (mode)
      SM_INT, SM_RST, SM_START:      tick = 1'b1;
      SM_ENC_B, SM_ENC_A, SM_ENC_AB: begin tick = enc_step; dn = enc_dn; end
      SM_GATE:                       tick = lvl;
      SM_EXT:                        tick = rise;
      default:                       tick = 1'b0;
    endcase
  end

  slv_cnt_core #(.CNT_W(CNT_W), .RST_PRESET(RST_PRESET)) u_core (
    .clk_i (clk_i), .rst_ni (rst_ni), .en_i (en_eff), .tick_i (tick), .down_i (dn),
    .reload_i (reload), .preset_i (preset_i), .preset_wr_i (preset_wr_i),
    .preload_en_i (preload_en_i), .count_o (count_o), .update_o (update_o)
  );

  AST_RUN_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == SM_START && rise && !run_clr_i) |=> run_q) else $error("run flag not set"); // R9
  AST_RUN_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_clr_i |=> !run_q) else $error("run flag not cleared"); // R9
  AST_EXT_NO_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == SM_EXT && !rise && !run_q) |=> $stable(count_o)) else $error("ext step without edge"); // R10
endmodule

// File: tb/tb_slv_timer.sv
module tb_slv_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  mode = '0;
  logic [1:0]  tsel = '0;
  logic        dir_down = 1'b0, enable = 1'b0, run_clr = 1'b0;
  logic [15:0] preset = '0;
  logic        pwr = 1'b0, preload = 1'b0;
  logic [3:0]  trig = '0;
  logic        enc_a = 1'b0, enc_b = 1'b0;
  logic [15:0] count;
  logic        update;

  always #4 clk = ~clk;

  slv_timer dut (
    .clk_i (clk), .rst_ni (rst_n), .mode_i (mode), .trig_sel_i (tsel),
    .dir_down_i (dir_down), .enable_i (enable), .run_clr_i (run_clr),
    .preset_i (preset), .preset_wr_i (pwr), .preload_en_i (preload),
    .trig_i (trig), .enc_a_i (enc_a), .enc_b_i (enc_b),
    .count_o (count), .update_o (update)
  );

  typedef struct { logic [15:0] cnt; logic upd; string tag; } exp_t;
  exp_t q[$];
  int total = 0, bad = 0;
  bit done = 0;

  logic [15:0] m_cnt = '0, m_act = 16'hFFFF, m_shd = 16'hFFFF;
  logic        m_trq = 0, m_a = 0, m_b = 0, m_run = 0;

  // reference model step; called at a falling edge after inputs are set
  task automatic cyc(input string tag);
    logic sel, rise, ea, eb, ua, ub, ka, kb, tick, dn, en, rl, wrap;
    logic [15:0] nc;
    exp_t e;
    sel  = trig[tsel];
    rise = sel & ~m_trq;
    ea = enc_a ^ m_a; eb = enc_b ^ m_b;
    ua = (mode == 3'd2) || (mode == 3'd3);
    ub = (mode == 3'd1) || (mode == 3'd3);
    ka = ua & ea & ~(ub & eb);
    kb = ub & eb & ~(ua & ea);
    en = enable | m_run;
    tick = 0; dn = dir_down;
    case (mode)
      3'd0, 3'd4, 3'd6: tick = 1;
      3'd1, 3'd2, 3'd3: begin tick = ka | kb; dn = ka ? (enc_a == enc_b) : (enc_b != enc_a); end
      3'd5: tick = sel;
      default: tick = rise;
    endcase
    rl   = (mode == 3'd4) & rise;
    wrap = en & tick & ~rl & (dn ? (m_cnt == 0) : (m_cnt == m_act));
    nc = m_cnt;
    if (en && rl)            nc = dn ? m_act : 16'd0;
    else if (wrap)           nc = dn ? m_act : 16'd0;
    else if (en && tick)     nc = dn ? m_cnt - 16'd1 : m_cnt + 16'd1;
    if (pwr && !preload)     m_act = preset;
    else if (wrap)           m_act = m_shd;
    if (pwr)                 m_shd = preset;
    if (run_clr)             m_run = 0;
    else if (mode == 3'd6 && rise) m_run = 1;
    m_trq = sel; m_a = enc_a; m_b = enc_b; m_cnt = nc;
    e.cnt = nc; e.upd = wrap; e.tag = tag;
    q.push_back(e);
    @(negedge clk);
  endtask

  task automatic run_n(input int n, input string tag);
    for (int i = 0; i < n; i++) cyc(tag);
  endtask

  // monitor / scoreboard
  always @(posedge clk) begin
    #2;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      total++;
      if (count !== e.cnt || update !== e.upd) begin
        bad++;
        $display("FAIL %s: count=%0d update=%0b expected count=%0d update=%0b",
                 e.tag, count, update, e.cnt, e.upd);
      end
    end
  end

  logic enc_fa [4] = '{1'b0, 1'b1, 1'b1, 1'b0};
  logic enc_fb [4] = '{1'b0, 1'b0, 1'b1, 1'b1};

  task automatic enc_walk(input string tag);
    for (int i = 1; i <= 8; i++) begin
      enc_a = enc_fa[i % 4]; enc_b = enc_fb[i % 4]; run_n(2, tag);
    end
    for (int i = 7; i >= 0; i--) begin
      enc_a = enc_fa[i % 4]; enc_b = enc_fb[i % 4]; run_n(2, tag);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    total++;
    if (count !== 16'd0 || update !== 1'b0) begin
      bad++;
      $display("FAIL R1: count=%0d update=%0b expected count=0 update=0", count, update);
    end
    rst_n = 1'b1;
    total++;
    if (count !== 16'd0 || update !== 1'b0) begin
      bad++;
      $display("FAIL R1: count=%0d update=%0b expected count=0 update=0", count, update);
    end
    // direct limit write
    preset = 16'd5; pwr = 1; cyc("R5"); pwr = 0;
    // disabled
    mode = 3'd0; run_n(3, "R3");
    // free running up and down
    enable = 1; run_n(9, "R4");
    dir_down = 1; run_n(9, "R4");
    dir_down = 0; run_n(3, "R2");
    // preload: limit 3 applies only after the next wrap
    preload = 1; preset = 16'd3; pwr = 1; cyc("R5"); pwr = 0;
    run_n(14, "R5");
    preload = 0;
    // encoder modes, dir_down set to show it is ignored
    dir_down = 1;
    mode = 3'd1; enc_walk("R6");
    mode = 3'd2; enc_walk("R6");
    mode = 3'd3; enc_walk("R6");
    enc_a = 1; enc_b = 1; run_n(2, "R6");
    enc_a = 0; enc_b = 0; run_n(2, "R6");
    dir_down = 0;
    // reset mode, trigger line 1
    preset = 16'd9; pwr = 1; cyc("R5"); pwr = 0;
    mode = 3'd4; tsel = 2'd1; run_n(4, "R7");
    trig[1] = 1; run_n(3, "R7"); trig[1] = 0; run_n(3, "R7");
    trig[0] = 1; run_n(2, "R11"); trig[0] = 0; run_n(2, "R11");
    dir_down = 1; run_n(2, "R7");
    trig[1] = 1; run_n(2, "R7"); trig[1] = 0; run_n(2, "R7");
    dir_down = 0;
    // gated mode
    mode = 3'd5; run_n(3, "R8");
    trig[1] = 1; run_n(4, "R8"); trig[1] = 0; run_n(3, "R8");
    trig[1] = 1; run_n(2, "R8"); trig[1] = 0; run_n(1, "R8");
    // trigger start, line 0
    mode = 3'd6; tsel = 2'd0; enable = 0; run_n(3, "R9");
    trig[0] = 1; run_n(5, "R9"); trig[0] = 0; run_n(3, "R9");
    run_clr = 1; cyc("R9"); run_clr = 0; run_n(3, "R9");
    trig[0] = 1; run_clr = 1; cyc("R9"); run_clr = 0; trig[0] = 0; run_n(3, "R9");
    // external clock on line 3, enabled
    enable = 1; mode = 3'd7; tsel = 2'd3; run_n(2, "R10");
    for (int i = 0; i < 12; i++) begin
      trig[3] = 1; run_n(2, "R10"); trig[3] = 0; run_n(1, "R10");
    end
    trig[3] = 1; run_n(4, "R10"); trig[3] = 0; run_n(1, "R10");
    for (int i = 0; i < 3; i++) begin
      trig[2] = 1; run_n(1, "R11"); trig[2] = 0; run_n(1, "R11");
    end
    run_n(2, "R10");
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule